// File: doc/BRIEF.md
# Load/Store Alignment Exception Checker

This block sits beside the load/store decode stage. Each cycle it can receive one decoded memory operation: the class of the operation, the encoded operand size, the low bits of the effective address, and a flag that says whether an exception of higher priority is already pending for that operation. It decides whether the access breaks the alignment rules and raises a registered exception flag together with a short reason code, one cycle after the operation is presented.

Three rules apply. A single integer access must sit on a boundary equal to its operand size, but only while the strict-alignment control is set. A multiple-word transfer always needs a word-aligned address, whatever the control says. A byte-string transfer is never flagged. A pending exception of higher priority suppresses the report. When no valid operation is presented, the outputs clear on the next cycle.

Top module: `lsAlignChk`

## Requirements
- R1: After a synchronous active-high reset, alignExc is 0 and alignCause is 2'b00.
- R2: Flag and code are registered: they reflect the operation presented at a rising edge from just after that edge until the next edge.
- R3: A single access (opClass 2'b00) with sizeCode s (0=1 byte, 1=2, 2=4, 3=8 bytes) is misaligned when any address bit below bit s is 1. When strictAlign is 1 it then raises alignExc=1 with alignCause=2'b01.
- R4: A misaligned single access with strictAlign 0 raises no exception (alignExc 0, cause 2'b00).
- R5: A multiple access (opClass 2'b01) whose addrLow[1:0] is not 2'b00 raises alignExc=1 with alignCause=2'b10, whatever strictAlign and sizeCode are.
- R6: A string access (opClass 2'b10) never raises the exception, whatever the address, size or strictAlign.
- R7: When priorExc is 1, no exception is raised (alignExc 0, cause 2'b00).
- R8: When opValid is 0, the next cycle shows alignExc 0 and alignCause 2'b00, whatever the other inputs are.
- R9: alignExc is 1 exactly when alignCause is not 2'b00. Class code 2'b11 is reserved and never flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | Operation is present this cycle |
| opClass | input | 2 | 00 single, 01 multiple, 10 string, 11 reserved |
| sizeCode | input | 2 | log2 of the operand size in bytes |
| addrLow | input | 3 | Low effective-address bits |
| strictAlign | input | 1 | Enforce operand-size alignment for single accesses |
| priorExc | input | 1 | Higher-priority exception pending |
| alignExc | output | 1 | Registered alignment exception |
| alignCause | output | 2 | Registered reason code |

## Verification
The bench sweeps every combination of class, size, address, strict control, prior flag and valid, and computes the expected result by arithmetic on the address modulo the size. It targets the size boundaries where an off-by-one mask would wrongly flag aligned halfwords or miss a misaligned doubleword. It also checks multiple accesses with strictAlign at 0, where a design that wrongly gated them by the control bit would stay silent. Further targets are string accesses at odd addresses, which a design that treated strings like singles would flag, and a pending prior exception, which a design that ignored priority would override. The one-cycle latency is checked by changing the inputs straight after each edge.

// File: rtl/lsAlignPkg.sv
package lsAlignPkg;
  localparam int ADDR_W = 3;
  localparam int SIZE_W = 2;

  typedef enum logic [1:0] {
    CLS_SINGLE = 2'b00,
    CLS_MULTI  = 2'b01,
    CLS_STRING = 2'b10,
    CLS_RSVD   = 2'b11
  } opClassT;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_SINGLE = 2'b01,
    CAUSE_MULTI  = 2'b10
  } causeT;

  typedef struct packed {
    logic load;
    logic raiseSingle;
    logic raiseMulti;
  } strobeT;
endpackage

// File: rtl/lsAlignCtl.sv
module lsAlignCtl
  import lsAlignPkg::*;
#(
  parameter int ADDR_W = lsAlignPkg::ADDR_W,
  parameter int SIZE_W = lsAlignPkg::SIZE_W
) (
  input  logic              opValid,
  input  logic [1:0]        opClass,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [ADDR_W-1:0] addrLow,
  input  logic              strictAlign,
  input  logic              priorExc,
  output strobeT            strobe
);
  localparam int NBITS = ADDR_W;

  logic [NBITS-1:0] sizeMask;
  logic singleMis;
  logic multiMis;
  logic allowed;

  // Each mask bit is set when it lies below the operand size boundary.
  for (genvar b = 0; b < NBITS; b++) begin : gMask
    assign sizeMask[b] = (b < int'(sizeCode));
  end

  assign singleMis = |(addrLow & sizeMask);
  assign multiMis  = |addrLow[1:0];
  assign allowed   = opValid && !priorExc;

  always_comb begin
    strobe = '0;
    strobe.load = 1'b1;
    if (allowed) begin
      unique case (opClassT'(opClass))
        CLS_SINGLE: strobe.raiseSingle = strictAlign && singleMis;
        CLS_MULTI:  strobe.raiseMulti  = multiMis;
        default:    ;
      endcase
    end
  end

  always_comb begin
    AST_ONE_RAISE: assert (!(strobe.raiseSingle && strobe.raiseMulti)); // R9
  end
endmodule

// File: rtl/lsAlignDp.sv
module lsAlignDp
  import lsAlignPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  strobeT     strobe,
  input  logic       opValid,
  input  logic       priorExc,
  output logic       alignExc,
  output logic [1:0] alignCause
);
  always_ff @(posedge clk) begin
    if (rst) begin
      alignExc   <= 1'b0;
      alignCause <= CAUSE_NONE;
    end else if (strobe.load) begin
      alignExc   <= strobe.raiseSingle | strobe.raiseMulti;
      alignCause <= strobe.raiseMulti  ? CAUSE_MULTI :
                    strobe.raiseSingle ? CAUSE_SINGLE : CAUSE_NONE;
    end
  end

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    alignExc == (alignCause != CAUSE_NONE)); // R9
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> !alignExc); // R8
  AST_PRIOR_MASK: assert property (@(posedge clk) disable iff (rst)
    priorExc |=> !alignExc); // R7
  AST_NO_RSVD: assert property (@(posedge clk) disable iff (rst)
    alignCause != 2'b11); // R9
endmodule

// File: rtl/lsAlignChk.sv
module lsAlignChk
  import lsAlignPkg::*;
#(
  parameter int ADDR_W = lsAlignPkg::ADDR_W,
  parameter int SIZE_W = lsAlignPkg::SIZE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [1:0]        opClass,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [ADDR_W-1:0] addrLow,
  input  logic              strictAlign,
  input  logic              priorExc,
  output logic              alignExc,
  output logic [1:0]        alignCause
);
  strobeT strobe;

  lsAlignCtl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) uCtl (
    .opValid(opValid), .opClass(opClass), .sizeCode(sizeCode),
    .addrLow(addrLow), .strictAlign(strictAlign), .priorExc(priorExc),
    .strobe(strobe)
  );

  lsAlignDp uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .opValid(opValid),
    .priorExc(priorExc), .alignExc(alignExc), .alignCause(alignCause)
  );

  AST_STRING_QUIET: assert property (@(posedge clk) disable iff (rst)
    (opValid && opClass == 2'b10) |=> !alignExc); // R6
  AST_LAX_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (opValid && opClass == 2'b00 && !strictAlign) |=> !alignExc); // R4
  AST_MULTI_WORD: assert property (@(posedge clk) disable iff (rst)
    (opValid && !priorExc && opClass == 2'b01 && addrLow[1:0] != 2'b00)
    |=> (alignExc && alignCause == 2'b10)); // R5
endmodule

// File: tb/sim_lsAlignChk.sv
module sim_lsAlignChk;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic opValid = 1'b0;
  logic [1:0] opClass = '0;
  logic [1:0] sizeCode = '0;
  logic [2:0] addrLow = '0;
  logic strictAlign = 1'b0;
  logic priorExc = 1'b0;
  logic alignExc;
  logic [1:0] alignCause;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsAlignChk u0 (
    .clk(clk), .rst(rst), .opValid(opValid), .opClass(opClass),
    .sizeCode(sizeCode), .addrLow(addrLow), .strictAlign(strictAlign),
    .priorExc(priorExc), .alignExc(alignExc), .alignCause(alignCause)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b (cls=%0d sz=%0d a=%0d st=%0d pr=%0d v=%0d)",
               req, act, exp, opClass, sizeCode, addrLow, strictAlign, priorExc, opValid);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {alignExc, alignCause}, 3'b000);
    rst = 1'b0;
    for (int v = 0; v < 2; v++)
      for (int pr = 0; pr < 2; pr++)
        for (int st = 0; st < 2; st++)
          for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++)
              for (int a = 0; a < 8; a++) begin
                logic [2:0] exp;
                string req;
                int bytes;
                bytes = 1 << s;
                exp = 3'b000;
                if (v == 0) req = "R8";
                else if (pr == 1) req = "R7";
                else if (c == 2) req = "R6";
                else if (c == 3) req = "R9";
                else if (c == 1) begin
                  req = "R5";
                  if (a % 4 != 0) exp = 3'b110;
                end else if (st == 0) req = "R4";
                else begin
                  req = "R3";
                  if (a % bytes != 0) exp = 3'b101;
                end
                opValid = v[0]; priorExc = pr[0]; strictAlign = st[0];
                opClass = c[1:0]; sizeCode = s[1:0]; addrLow = a[2:0];
                @(posedge clk);
                #1;
                // R2: inputs change right after the edge; output must hold the latched result
                opValid = ~opValid; addrLow = ~addrLow; opClass = ~opClass;
                #2;
                check(req, {alignExc, alignCause}, exp);
              end
    finished = 1;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
  end

  initial begin
    wait (finished || total > 0 && $time > CLK_PERIOD * 199000);
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule